// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write single bytes in an asynchronous static RAM of 512K locations by 8 bits. The RAM has active-low chip select, write enable and output enable, and a shared data bus. A requester presents an address, a write flag and write data with `req_valid` while `req_idle` is high. The controller then walks the RAM through a fixed strobe sequence. It raises `done` for one cycle when the access is over, and for reads it leaves the fetched byte in `rdata`.

All waits are whole clock cycles. Each one is the ceiling of a nanosecond timing figure divided by the clock period, and never less than one cycle. Every strobe, the address and the data-drive enable come straight from flops. During a write, output enable stays high, so the shorter write pulse applies. After a read, the controller leaves the bus undriven for a turnaround interval so that it never drives the bus while the RAM is still releasing it.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `req_idle` is high, chip select, write enable and output enable are all high (standby) and `mem_dout_en` is low.
- R2: A write holds chip select low with output enable high for one setup cycle and then for WP_CYC cycles with write enable low. The byte on `mem_dout` at the end of that pulse is the one stored.
- R3: `mem_dout_en` is high only while chip select is low and output enable is high. It is also high in the setup cycle just before write enable falls.
- R4: A read holds chip select and output enable low with write enable high for RD_CYC cycles. `rdata` takes the RAM byte at the edge that closes this window and keeps it until the next read completes.
- R5: `done` is high for exactly one cycle per accepted request. A request driven in the cycle before edge 0 shows `done` after edge 1+WP_CYC for a write and after edge RD_CYC for a read.
- R6: `req_valid` is ignored while `req_idle` is low. The address and write data stay as they are, and no extra access happens.
- R7: After a read, all strobes stay high and `req_idle` stays low for TURN_CYC cycles. The data bus is never driven in the cycle right after output enable rises.
- R8: The address does not change while chip select is low.
- R9: RD_CYC = ceil(max(tRC, tAA)/period), WP_CYC = max(ceil(max(tWP, tDW, tAW)/period), ceil(tWC/period) - 1), and TURN_CYC = ceil(tHZ/period). Each count is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted only while `req_idle` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| req_idle | output | 1 | Controller idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 19 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dout | output | 8 | Data toward the RAM |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` on the shared bus |
| mem_din | input | 8 | Data from the shared bus |

## Verification
A stuck or miscounted state shows at the ports within one access. The pulse-width, setup and access windows measured by the bench's RAM model come up short or too long, and `done` arrives off its expected edge. A wrong state-to-strobe decode shows on the very next edge, for example as output enable low during a write, bus drive while the RAM drives, or no idle gap after a read. A capture at the wrong edge, or an address or data latch that is not held, corrupts the byte stored or returned. The read-back of the next access exposes it.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 10,
  parameter int T_AA_NS       = 10,
  parameter int T_WC_NS       = 10,
  parameter int T_WP_NS       = 7,
  parameter int T_DW_NS       = 5,
  parameter int T_AW_NS       = 7,
  parameter int T_HZ_NS       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_idle,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC   = cyc(max2(T_RC_NS, T_AA_NS));
  localparam int WP_CYC   = max2(cyc(max2(T_WP_NS, max2(T_DW_NS, T_AW_NS))), cyc(T_WC_NS) - 1);
  localparam int TURN_CYC = cyc(T_HZ_NS);
  localparam int MAX_CYC  = max2(RD_CYC, max2(WP_CYC, TURN_CYC));
  localparam int CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_RACC, S_TURN} st_t;

  st_t           st, st_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          last, accept;

  assign last     = (cnt == '0);
  assign req_idle = (st == S_IDLE);
  assign accept   = req_idle && req_valid;

  always_comb begin
    st_d  = st;
    cnt_d = last ? cnt : cnt - 1'b1;
    case (st)
      S_IDLE: if (req_valid) begin
        st_d  = req_write ? S_WSET : S_RACC;
        cnt_d = req_write ? '0 : CW'(RD_CYC - 1);
      end
      S_WSET: begin
        st_d  = S_WPUL;
        cnt_d = CW'(WP_CYC - 1);
      end
      S_WPUL: if (last) st_d = S_IDLE;
      S_RACC: if (last) begin
        st_d  = S_TURN;
        cnt_d = CW'(TURN_CYC - 1);
      end
      S_TURN: if (last) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      mem_cs_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dout_en <= 1'b0;
      done        <= 1'b0;
      mem_addr    <= '0;
      mem_dout    <= '0;
      rdata       <= '0;
    end else begin
      st          <= st_d;
      cnt         <= cnt_d;
      mem_cs_n    <= !(st_d inside {S_WSET, S_WPUL, S_RACC});
      mem_we_n    <= (st_d != S_WPUL);
      mem_oe_n    <= (st_d != S_RACC);
      mem_dout_en <= (st_d inside {S_WSET, S_WPUL});
      done        <= last && (st == S_WPUL || st == S_RACC);
      if (accept) begin
        mem_addr <= req_addr;
        if (req_write) mem_dout <= req_wdata;
      end
      if (st == S_RACC && last) rdata <= mem_din;
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_idle,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dout,
  input logic              mem_dout_en
);

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_idle |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en));

  p_oe_high_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_dout_en));

  p_drive_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (!mem_cs_n && mem_oe_n));

  p_drive_before_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dout_en));

  p_read_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_idle |=> ($stable(mem_addr) && $stable(mem_dout)));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_dout_en && !req_idle));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .done(done),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en));

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  localparam int P      = 20;
  localparam int T_AA   = 45;
  localparam int T_WP   = 30;
  localparam int T_DW   = 5;
  localparam int T_AW   = 7;
  // R9: ceil(45/20)=3 read cycles, max(ceil(30/20)=2, ceil(10/20)-1=0)=2 pulse cycles, ceil(5/20)=1 turn cycle
  localparam int RD_EXP = 3;
  localparam int WP_EXP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_idle, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en;
  logic [7:0]  rdata, mem_dout, mem_din;
  logic [18:0] mem_addr;

  int checks = 0, fails = 0, cyc_cnt = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(P), .T_AA_NS(T_AA), .T_WP_NS(T_WP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_idle(req_idle), .done(done),
    .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din));

  // behavioural RAM, sampled mid-cycle
  logic [7:0] mem_arr [0:1023];
  wire mrd = !mem_cs_n && mem_we_n && !mem_oe_n;
  assign mem_din = mrd ? mem_arr[mem_addr[9:0]] : 8'hFF;

  int v_wr = 0, v_drv = 0, v_rd = 0, v_turn = 0, v_addr = 0, v_stby = 0;
  int wr_c = 0, rd_c = 0, dstab = 0, astab = 0, since_rd = 100, wr_dst = 0, wr_ast = 0;
  logic prev_wr = 1'b0, prev_rd = 1'b0, prev_cs = 1'b0;
  logic [7:0]  prev_d = '0, wr_d = '0;
  logic [18:0] prev_a = '0, wr_a = '0;

  always @(negedge clk) if (rst_n) begin
    dstab = (mem_dout == prev_d) ? dstab + 1 : 1; prev_d = mem_dout;
    astab = (mem_addr == prev_a) ? astab + 1 : 1; prev_a = mem_addr;
    if (mem_cs_n && !(mem_we_n && mem_oe_n && !mem_dout_en)) v_stby++;
    if (!mem_cs_n && prev_cs && astab == 1) v_addr++;
    if (!mem_cs_n && !mem_we_n) begin
      wr_c++; wr_a = mem_addr; wr_d = mem_dout; wr_dst = dstab; wr_ast = astab;
      if (!mem_oe_n) v_wr++;
      if (!mem_dout_en) v_drv++;
    end else if (prev_wr) begin
      if (wr_c * P < T_WP || wr_dst * P < T_DW || wr_ast * P < T_AW) v_wr++;
      mem_arr[wr_a[9:0]] = wr_d;
      wr_c = 0;
    end
    if (mem_dout_en && (mem_cs_n || !mem_oe_n)) v_drv++;
    if (mrd) begin
      rd_c++; since_rd = 0;
    end else begin
      if (prev_rd) begin
        if (rd_c * P < T_AA) v_rd++;
        rd_c = 0;
      end
      since_rd++;
      if (mem_dout_en && since_rd < 2) v_turn++;
    end
    prev_wr = !mem_cs_n && !mem_we_n; prev_rd = mrd; prev_cs = !mem_cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !ended) begin
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      summary();
    end
  end

  task automatic wait_done(output int lat);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 50);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d, output int lat);
    while (!req_idle) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk); lat = 1; req_valid = 1'b0;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    @(negedge clk);
    chk(!done, "R5 done width after write", done, 0);
  endtask

  task automatic do_read(input logic [18:0] a, output logic [7:0] d, output int lat);
    while (!req_idle) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk); lat = 1; req_valid = 1'b0;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    d = rdata;
  endtask

  task automatic t_reset();
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dout_en && req_idle && !done, "R1 idle after reset", {mem_dout_en, req_idle, done}, 3'b010);
  endtask

  task automatic t_write_read();
    int lat; logic [7:0] d;
    logic [18:0] addrs [3] = '{19'h00000, 19'h7FFFF, 19'h12345};
    logic [7:0]  vals  [3] = '{8'hA5, 8'h5A, 8'hC3};
    foreach (addrs[i]) begin
      do_write(addrs[i], vals[i], lat);
      chk(lat == WP_EXP + 2, "R9 write latency", lat, WP_EXP + 2);
    end
    foreach (addrs[i]) begin
      do_read(addrs[i], d, lat);
      chk(d == vals[i], "R4 read-back data", d, vals[i]);
      chk(lat == RD_EXP + 1, "R5 read latency", lat, RD_EXP + 1);
      @(negedge clk);
    end
    chk(v_wr == 0, "R2 write pulse timing", v_wr, 0);
    chk(v_rd == 0, "R4 read access window", v_rd, 0);
  endtask

  task automatic t_busy_ignore();
    int lat; logic [7:0] d;
    do_write(19'h00010, 8'h11, lat);
    while (!req_idle) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00020; req_wdata = 8'h22;
    @(negedge clk);
    req_addr = 19'h00010; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(lat);
    repeat (3) @(negedge clk);
    chk(req_idle, "R6 idle after ignored request", req_idle, 1);
    do_read(19'h00010, d, lat);
    chk(d == 8'h11, "R6 busy request ignored", d, 8'h11);
    @(negedge clk);
    do_read(19'h00020, d, lat);
    chk(d == 8'h22, "R6 accepted write stored", d, 8'h22);
  endtask

  task automatic t_turnaround();
    int lat; logic [7:0] d;
    do_read(19'h12345, d, lat);
    chk(!req_idle && mem_oe_n && mem_cs_n, "R7 turnaround after read", req_idle, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00033; req_wdata = 8'h77;
    @(negedge clk);
    chk(req_idle && !mem_dout_en, "R7 idle after turnaround", req_idle, 1);
    @(negedge clk); req_valid = 1'b0;
    chk(mem_dout_en && mem_we_n && !mem_cs_n, "R3 setup cycle drive", {mem_dout_en, mem_we_n, mem_cs_n}, 3'b110);
    @(negedge clk);
    chk(!mem_we_n && mem_oe_n, "R2 pulse with oe high", {mem_we_n, mem_oe_n}, 2'b01);
    wait_done(lat);
    chk(d == rdata, "R4 rdata holds across write", rdata, d);
    chk(v_turn == 0 && v_drv == 0, "R3 R7 bus ownership", v_turn + v_drv, 0);
    do_read(19'h00033, d, lat);
    chk(d == 8'h77, "R2 back-to-back write stored", d, 8'h77);
  endtask

  task automatic t_standby();
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en, "R1 standby between requests",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en}, 4'b1110);
    chk(v_stby == 0, "R1 standby strobes", v_stby, 0);
    chk(v_addr == 0, "R8 address held while selected", v_addr, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem_arr[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_read();
    t_busy_ignore();
    t_turnaround();
    t_standby();
    summary();
  end
endmodule